// File: doc/BRIEF.md
# I2C Byte-Memory Target with Hardware Write Lock

This block is an I2C target that sits in front of a 128 x 8 byte memory. It samples SCL and SDA on a fast system clock. It detects START and STOP conditions and decodes a device-select byte. After the select byte it takes either a word address and data bytes (a write) or streams bytes out of the memory (a read). SDA is open drain, so the block only ever pulls the line low through an enable output. The memory sits outside the block behind a synchronous port: one write strobe, and read data that follows the address one clock later.

A write-lock input protects the memory. While it is high, the select byte and the address byte are still acknowledged, so a host can still set the read pointer. Every data byte, however, goes unacknowledged and is discarded. An unconnected lock input must be tied low, and low means writes are allowed. The word address advances after each byte transferred and wraps within the 128 locations.

Top module: `i2c_eeprom_wp`

## Requirements
- R1: After reset the SDA pull-down enable is low and no memory write strobe is issued.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle and releases SDA. A START (SDA falling while SCL is high) restarts byte reception at any point, and a partly received byte is dropped. A transaction with no data byte writes nothing and keeps the loaded address.
- R3: A select byte is acknowledged only when its upper seven bits equal 1010000. Bit 0 of that byte is the direction: 0 means write, 1 means read. On any other select byte the block does not acknowledge and ignores the bus until the next START.
- R4: In a write, the byte after the select byte is the word address, and only its low 7 bits are used. Every following byte is written to memory at the current address. Bits are taken MSB first on SCL rising edges, and each accepted byte is acknowledged by holding SDA low through the ninth SCL clock.
- R5: The word address increments after every data byte written or read, and wraps from 7Fh to 00h.
- R6: In a read, bytes from the current address are driven MSB first. Reading continues while the host acknowledges. After a host non-acknowledge the block releases SDA and stays off the bus.
- R7: While the lock input is high, the select and address bytes are acknowledged. Data bytes are not acknowledged, memory is not written and the address does not advance.
- R8: The SDA pull-down enable changes only while SCL is low.
- R9: Each accepted data byte produces exactly one single-cycle memory write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | High pulls SDA low; low releases the line |
| wp_i | input | 1 | Write lock; tie low when unused |
| mem_addr_o | output | 7 | Memory address for reads and writes |
| mem_we_o | output | 1 | One-cycle memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |

## Verification
The SDA timing assertions assume that each SCL low phase lasts longer than the synchronizer plus the edge-detect delay, so that the block's enable changes land while the raw SCL input is still low. The bench keeps SCL low for twelve system clocks per bit, and it changes its own SDA only in the middle of the low phase. The write-lock assertion assumes the lock input holds steady across a data byte. The bench changes the lock only between transactions, after a STOP.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_e;
  typedef enum logic [1:0] {BY_DEV, BY_ADDR, BY_DATA} byte_e;
endpackage

// File: rtl/ee_edge_det.sv
module ee_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_o;
    end
  end

  assign scl_s      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (inc_i)  addr_o <= addr_o + 1'b1; // natural wrap at 2**AW
  end
endmodule

// File: rtl/ee_byte_shift.sv
module ee_byte_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (load_i)  data_o <= load_val_i;
    else if (shift_i) data_o <= {data_o[DW-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_eeprom_wp.sv
module i2c_eeprom_wp #(
  parameter int unsigned AW          = 7,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_CODE    = 7'b1010000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          wp_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  import ee_pkg::*;

  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  ee_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  st_e           st_q, st_d;
  byte_e         role_q, role_d;
  logic          rw_q, rw_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          oe_q, oe_d;
  logic          we_q, we_d;
  logic [AW-1:0] waddr_q;
  logic [DW-1:0] wdata_q;

  logic          sh_load, sh_shift, sh_bit;
  logic [DW-1:0] sh_q;
  logic          a_load, a_inc;
  logic [AW-1:0] addr_q;

  ee_byte_shift #(.DW(DW)) u_shift (
    .clk_i, .rst_ni,
    .load_i(sh_load), .load_val_i(mem_rdata_i),
    .shift_i(sh_shift), .bit_i(sh_bit), .data_o(sh_q)
  );

  ee_addr_ctr #(.AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .load_i(a_load), .load_val_i(sh_q[AW-1:0]),
    .inc_i(a_inc), .addr_o(addr_q)
  );

  always_comb begin
    st_d     = st_q;
    role_d   = role_q;
    rw_d     = rw_q;
    cnt_d    = cnt_q;
    oe_d     = oe_q;
    we_d     = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_bit   = sda_s;
    a_load   = 1'b0;
    a_inc    = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d   = ST_RX;
      role_d = BY_DEV;
      cnt_d  = '0;
      oe_d   = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_shift = 1'b1;
            cnt_d    = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            st_d  = ST_ACK;
            case (role_q)
              BY_DEV: begin
                if (sh_q[DW-1:1] == DEV_CODE) begin
                  oe_d = 1'b1;
                  rw_d = sh_q[0];
                end else begin
                  st_d = ST_IDLE;
                end
              end
              BY_ADDR: begin
                oe_d   = 1'b1;
                a_load = 1'b1;
              end
              default: begin
                if (!wp_i) begin // locked data bytes: no ack, no write
                  oe_d  = 1'b1;
                  we_d  = 1'b1;
                  a_inc = 1'b1;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (role_q == BY_DEV && rw_q) begin
              st_d    = ST_TX;
              sh_load = 1'b1;
              a_inc   = 1'b1;
              oe_d    = ~mem_rdata_i[DW-1];
            end else begin
              oe_d   = 1'b0;
              st_d   = ST_RX;
              role_d = (role_q == BY_DEV) ? BY_ADDR : BY_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_d  = 1'b0;
              cnt_d = '0;
              st_d  = ST_MACK;
            end else begin
              sh_shift = 1'b1;
              sh_bit   = 1'b1;
              cnt_d    = cnt_q + 1'b1;
              oe_d     = ~sh_q[DW-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_s) begin
            st_d = ST_IDLE;
          end else if (scl_fall) begin
            st_d    = ST_TX;
            sh_load = 1'b1;
            a_inc   = 1'b1;
            oe_d    = ~mem_rdata_i[DW-1];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      role_q  <= BY_DEV;
      rw_q    <= 1'b0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      st_q   <= st_d;
      role_q <= role_d;
      rw_q   <= rw_d;
      cnt_q  <= cnt_d;
      oe_q   <= oe_d;
      we_q   <= we_d;
      if (we_d) begin
        waddr_q <= addr_q;
        wdata_q <= sh_q;
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wdata_q;
  assign mem_addr_o  = we_q ? waddr_q : addr_q;
endmodule

// File: rtl/i2c_eeprom_wp_chk.sv
module i2c_eeprom_wp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic wp_i,
  input logic sda_oe_o,
  input logic mem_we_o,
  input logic idle_i
);
  // R8
  oe_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
  // R8
  oe_fall_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_i);
  // R9
  we_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  // R7
  wp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !$past(wp_i));
  // R2
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_oe_o);
endmodule

bind i2c_eeprom_wp i2c_eeprom_wp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .wp_i(wp_i),
  .sda_oe_o(sda_oe_o), .mem_we_o(mem_we_o),
  .idle_i(st_q == ee_pkg::ST_IDLE)
);

// File: tb/i2c_eeprom_wp_tb.sv
module i2c_eeprom_wp_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, we;
  logic [6:0] maddr;
  logic [7:0] wdata, rdata;
  logic sda_bus;
  logic [7:0] mem_q [128];
  logic [7:0] exp_q [128];
  int total = 0, bad = 0, we_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_eeprom_wp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .wp_i(wp), .mem_addr_o(maddr), .mem_we_o(we),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i ^ 8'h5A);
  endfunction

  function automatic logic [7:0] pat(int k, int salt);
    return 8'(k * 37 + salt * 11 + 3);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem_q[i] <= init_val(i);
    end else if (we) begin
      mem_q[maddr] <= wdata;
    end
    rdata <= mem_q[maddr];
  end

  always @(posedge clk) if (rst_n && we) we_cnt++;

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = !sda_bus;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_addr(logic [7:0] a, string req);
    bit ack;
    bus_start();
    send_byte(8'hA0, ack); chk(ack, req, ack, 1);
    send_byte(a, ack);     chk(ack, req, ack, 1);
  endtask

  task automatic read_run(int start_a, int n, string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hA1, ack); chk(ack, req, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == exp_q[(start_a + k) % 128], req, b, exp_q[(start_a + k) % 128]);
    end
    bus_stop();
  endtask

  task automatic write_run(logic [7:0] a, int n, int salt, string req);
    bit ack;
    int w0;
    w0 = we_cnt;
    set_addr(a, req);
    for (int k = 0; k < n; k++) begin
      send_byte(pat(k, salt), ack);
      chk(ack, req, ack, 1);
      exp_q[(int'(a[6:0]) + k) % 128] = pat(k, salt);
    end
    bus_stop();
    tick(4);
    // R9: one strobe per accepted byte
    chk(we_cnt - w0 == n, "R9", we_cnt - w0, n);
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    int w0;
    logic [7:0] bad_codes [3];
    bad_codes[0] = 8'hA2; bad_codes[1] = 8'h20; bad_codes[2] = 8'hE1;
    for (int i = 0; i < 128; i++) exp_q[i] = init_val(i);
    tick(5);
    // R1
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    chk(we == 1'b0, "R1", we, 0);
    rst_n = 1'b1;
    tick(10);
    chk(sda_oe == 1'b0 && we_cnt == 0, "R1", sda_oe, 0);

    // R3: non-matching select codes are ignored
    w0 = we_cnt;
    foreach (bad_codes[c]) begin
      bus_start();
      send_byte(bad_codes[c], ack); chk(!ack, "R3", ack, 0);
      send_byte(8'h05, ack);        chk(!ack, "R3", ack, 0);
      send_byte(8'h77, ack);        chk(!ack, "R3", ack, 0);
      bus_stop();
    end
    chk(we_cnt == w0, "R3", we_cnt - w0, 0);

    // R4: full sweep write from 00h, R5: wrap write at 7Eh
    write_run(8'h00, 128, 1, "R4");
    write_run(8'h7E, 4, 2, "R5");
    // R4: address MSB ignored
    write_run(8'h85, 1, 3, "R4");

    // R6: full read sweep, then wrap read (R5)
    set_addr(8'h00, "R6");
    read_run(0, 128, "R6");
    tick(4 * Q);
    chk(sda_oe == 1'b0, "R6", sda_oe, 0);
    set_addr(8'h7D, "R5");
    read_run(8'h7D, 6, "R5");

    // R7: locked write
    wp = 1'b1;
    tick(Q);
    w0 = we_cnt;
    set_addr(8'h10, "R7");
    for (int k = 0; k < 3; k++) begin
      send_byte(pat(k, 9), ack);
      chk(!ack, "R7", ack, 0);
    end
    bus_stop();
    wp = 1'b0;
    tick(Q);
    chk(we_cnt == w0, "R7", we_cnt - w0, 0);
    read_run(8'h10, 2, "R7");

    // R2: stop after address only; start mid-byte
    w0 = we_cnt;
    set_addr(8'h30, "R2");
    bus_stop();
    tick(Q);
    chk(sda_oe == 1'b0, "R2", sda_oe, 0);
    read_run(8'h30, 1, "R2");
    set_addr(8'h40, "R2");
    send_bits(8'hC3, 4);
    bus_start();
    send_byte(8'hA1, ack); chk(ack, "R2", ack, 1);
    recv_byte(1'b0, b);
    chk(b == exp_q[8'h40], "R2", b, exp_q[8'h40]);
    bus_stop();
    tick(4);
    chk(we_cnt == w0, "R2", we_cnt - w0, 0);

    // R4: memory contents match written model
    for (int i = 0; i < 128; i++)
      chk(mem_q[i] == exp_q[i], "R4", mem_q[i], exp_q[i]);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule